// File: doc/BRIEF.md
# HDLC Receive Hunt and Framing Controller

This block runs the receive side of one HDLC channel. It takes a serial bit stream, qualified by a per-bit valid strobe. It detects the flag pattern, removes zeros that the transmitter inserted, and assembles the remaining bits into octets, least significant bit first. Completed octets leave on a one-cycle valid/data pair. The block does not hold buffer memory, descriptors or a CRC engine. It only produces the control strobes that such logic needs: a buffer-close pulse, the index of the buffer in use, a CRC-reset pulse and a receive interrupt.

Software steers the channel with two inputs: a receive enable level and a one-cycle hunt command. A hunt command always gives up the frame in progress and closes the current buffer. The next frame then goes to the following buffer. Once an enabled receiver has been switched off, raising the enable again has no effect until a hunt command has been given. This guarantees that each restart begins in a fresh buffer.

Top module: `hdlcRxHunt`

## Requirements
- R1: After reset, bufIdx is 0 and dataValid, bufClose, crcReset and rxIrq are low. Until rxEnable is first raised, the bit stream has no effect. Raising rxEnable starts hunting for a flag.
- R2: A flag is a zero, six ones and a zero. A flag found while hunting or inside a frame gives a one-cycle crcReset pulse. A flag found while hunting starts a frame.
- R3: Inside a frame, every eight data bits form one octet, with the first received bit at bit 0. The octet is presented on dataOctet with a one-cycle dataValid pulse in the cycle after its last bit is sampled.
- R4: Inside a frame, a zero that follows five consecutive ones is removed and does not count as data.
- R5: A flag that ends a frame holding at least one octet gives a one-cycle bufClose pulse. During that pulse bufIdx still shows the closed buffer, and it advances in the next cycle. Flags with no octet between them close nothing.
- R6: A seventh consecutive one inside a frame aborts it. The receiver returns to hunting without closing the buffer, and bits up to the next flag are not delivered.
- R7: A hunt command (huntCmd high for one cycle) drops the frame in progress. It pulses bufClose and crcReset, advances bufIdx, and leaves the receiver hunting (or idle if rxEnable is low).
- R8: rxIrq pulses together with bufClose only when irqEnable was high in the cycle that caused the close.
- R9: bufIdx changes only after a bufClose pulse. It advances by one and wraps from lastIdx to 0.
- R10: Dropping rxEnable during reception abandons the frame without a close. Raising rxEnable again is ignored until a hunt command arrives, and reception then resumes in the next buffer.
- R11: When a hunt command arrives in the same cycle as the last bit of a closing flag, exactly one close occurs and bufIdx advances once. The receiver is left hunting, so unframed bits that follow are not delivered.
- R12: Cycles with rxBitValid low have no effect on framing, zero removal or octet assembly, whatever rxBit holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rxEnable | input | 1 | Receiver enable level |
| huntCmd | input | 1 | One-cycle hunt command strobe |
| irqEnable | input | 1 | Enables rxIrq on buffer close |
| lastIdx | input | IDX_W | Highest buffer index before wrap to 0 |
| rxBit | input | 1 | Serial receive bit |
| rxBitValid | input | 1 | rxBit carries a new bit this cycle |
| dataValid | output | 1 | dataOctet holds a received octet |
| dataOctet | output | 8 | Received octet, first bit in bit 0 |
| bufClose | output | 1 | One-cycle pulse closing the current buffer |
| bufIdx | output | IDX_W | Index of the buffer in use |
| crcReset | output | 1 | One-cycle pulse to restart the CRC |
| rxIrq | output | 1 | One-cycle receive-buffer interrupt |

## Verification
A hunt command and the closing flag of a frame can land in the same cycle. Both want to close the buffer and reset the CRC, and they disagree on whether a new frame begins. The bench forces this by raising huntCmd together with the final zero of a closing flag. It then counts bufClose pulses and compares bufIdx before and after. Finally it sends an unframed octet, which must not be delivered, proving the receiver went back to hunting rather than opening a frame.

// File: rtl/hdlcRxPkg.sv
package hdlcRxPkg;
  localparam int OCTET_W = 8;
  localparam int ONES_W  = 3;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_HUNT,
    ST_FRAME,
    ST_LOCKED
  } rxState_t;

  // control -> datapath strobes
  typedef struct packed {
    logic clearRun;
    logic takeData;
  } rxCtl_t;

  // datapath -> control events (combinational, current bit)
  typedef struct packed {
    logic flagSeen;
    logic abortSeen;
    logic octetDone;
  } rxEvt_t;
endpackage

// File: rtl/hdlcRxDeframe.sv
module hdlcRxDeframe
  import hdlcRxPkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               bitIn,
  input  logic               bitValid,
  input  rxCtl_t             ctl,
  output rxEvt_t             evt,
  output logic               dataValid,
  output logic [OCTET_W-1:0] dataOctet
);
  localparam int CNT_W = $clog2(OCTET_W);
  localparam logic [ONES_W-1:0] STUFF_RUN = ONES_W'(5);
  localparam logic [ONES_W-1:0] FLAG_RUN  = ONES_W'(6);
  localparam logic [ONES_W-1:0] RUN_MAX   = ONES_W'(7);
  localparam logic [CNT_W-1:0]  LAST_BIT  = CNT_W'(OCTET_W - 1);

  logic [ONES_W-1:0]  onesRun;
  logic [OCTET_W-2:0] shiftReg;
  logic [CNT_W-1:0]   bitCnt;
  logic               stuffSeen;
  logic               dataBit;

  always_comb begin
    evt.flagSeen  = bitValid && !bitIn && (onesRun == FLAG_RUN);
    evt.abortSeen = bitValid &&  bitIn && (onesRun == FLAG_RUN);
    stuffSeen     = bitValid && !bitIn && (onesRun == STUFF_RUN);
    // a bit is payload only while the preceding run of ones is short
    dataBit       = bitValid && (onesRun < STUFF_RUN);
    evt.octetDone = ctl.takeData && dataBit && (bitCnt == LAST_BIT);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      onesRun   <= '0;
      shiftReg  <= '0;
      bitCnt    <= '0;
      dataValid <= 1'b0;
      dataOctet <= '0;
    end else begin
      dataValid <= evt.octetDone;
      if (evt.octetDone)
        dataOctet <= {bitIn, shiftReg};

      if (ctl.clearRun)
        onesRun <= '0;
      else if (bitValid)
        onesRun <= bitIn ? ((onesRun == RUN_MAX) ? RUN_MAX : onesRun + 1'b1) : '0;

      if (!ctl.takeData || evt.flagSeen) begin
        bitCnt <= '0;
      end else if (dataBit) begin
        shiftReg <= {bitIn, shiftReg[OCTET_W-2:1]};
        bitCnt   <= (bitCnt == LAST_BIT) ? '0 : bitCnt + 1'b1;
      end
    end
  end

  AST_DATA_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    dataValid |=> !dataValid);                                   // R3
  AST_FLAG_REALIGNS: assert property (@(posedge clk) disable iff (!rstN)
    evt.flagSeen |=> (bitCnt == '0));                             // R2
  AST_STUFF_DROPPED: assert property (@(posedge clk) disable iff (!rstN)
    (stuffSeen && ctl.takeData) |=> $stable(bitCnt));            // R4
  AST_IDLE_BIT_INERT: assert property (@(posedge clk) disable iff (!rstN)
    (!bitValid && !ctl.clearRun) |=> $stable(onesRun));          // R12
endmodule

// File: rtl/hdlcRxCtrl.sv
module hdlcRxCtrl
  import hdlcRxPkg::*;
#(
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rxEnable,
  input  logic             huntCmd,
  input  logic             irqEnable,
  input  logic [IDX_W-1:0] lastIdx,
  input  rxEvt_t           evt,
  output rxCtl_t           ctl,
  output logic             bufClose,
  output logic             crcReset,
  output logic             rxIrq,
  output logic [IDX_W-1:0] bufIdx
);
  rxState_t state, nextState;
  logic     gotOctet;
  logic     flagOk;
  logic     closeNow;
  logic     crcNow;

  // precedence: hunt command, then disable, then stream events
  assign flagOk = evt.flagSeen && rxEnable && !huntCmd;

  always_comb begin
    nextState = state;
    if (huntCmd) begin
      nextState = rxEnable ? ST_HUNT : ST_IDLE;
    end else begin
      case (state)
        ST_IDLE:   if (rxEnable) nextState = ST_HUNT;
        ST_HUNT:   if (!rxEnable) nextState = ST_LOCKED;
                   else if (evt.flagSeen) nextState = ST_FRAME;
        ST_FRAME:  if (!rxEnable) nextState = ST_LOCKED;
                   else if (evt.abortSeen) nextState = ST_HUNT;
        ST_LOCKED: nextState = ST_LOCKED;
        default:   nextState = ST_IDLE;
      endcase
    end
  end

  always_comb begin
    ctl.clearRun = (state == ST_IDLE) || (state == ST_LOCKED);
    ctl.takeData = (state == ST_FRAME) && rxEnable && !huntCmd;
    closeNow     = huntCmd || ((state == ST_FRAME) && flagOk && gotOctet);
    crcNow       = huntCmd || (((state == ST_HUNT) || (state == ST_FRAME)) && flagOk);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      gotOctet <= 1'b0;
      bufClose <= 1'b0;
      crcReset <= 1'b0;
      rxIrq    <= 1'b0;
      bufIdx   <= '0;
    end else begin
      state    <= nextState;
      gotOctet <= ((nextState == ST_FRAME) && !flagOk) ? (gotOctet || evt.octetDone) : 1'b0;
      bufClose <= closeNow;
      crcReset <= crcNow;
      rxIrq    <= closeNow && irqEnable;
      if (bufClose)
        bufIdx <= (bufIdx >= lastIdx) ? '0 : bufIdx + 1'b1;
    end
  end

  AST_HUNT_STROBES: assert property (@(posedge clk) disable iff (!rstN)
    huntCmd |=> (bufClose && crcReset));                          // R7
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rstN)
    rxIrq |-> (bufClose && $past(irqEnable)));                    // R8
  AST_IDX_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !bufClose |=> $stable(bufIdx));                               // R9
  AST_LOCK_STICKS: assert property (@(posedge clk) disable iff (!rstN)
    ((state == ST_LOCKED) && !huntCmd) |=> (state == ST_LOCKED)); // R10
  AST_ABORT_TO_HUNT: assert property (@(posedge clk) disable iff (!rstN)
    ((state == ST_FRAME) && evt.abortSeen && rxEnable && !huntCmd) |=> (state == ST_HUNT)); // R6
  AST_HUNT_NO_FRAME: assert property (@(posedge clk) disable iff (!rstN)
    huntCmd |=> (state != ST_FRAME));                             // R11
endmodule

// File: rtl/hdlcRxHunt.sv
module hdlcRxHunt
  import hdlcRxPkg::*;
#(
  parameter int IDX_W = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               rxEnable,
  input  logic               huntCmd,
  input  logic               irqEnable,
  input  logic [IDX_W-1:0]   lastIdx,
  input  logic               rxBit,
  input  logic               rxBitValid,
  output logic               dataValid,
  output logic [OCTET_W-1:0] dataOctet,
  output logic               bufClose,
  output logic [IDX_W-1:0]   bufIdx,
  output logic               crcReset,
  output logic               rxIrq
);
  rxCtl_t ctl;
  rxEvt_t evt;

  hdlcRxDeframe u_deframe (
    .clk       (clk),
    .rstN      (rstN),
    .bitIn     (rxBit),
    .bitValid  (rxBitValid),
    .ctl       (ctl),
    .evt       (evt),
    .dataValid (dataValid),
    .dataOctet (dataOctet)
  );

  hdlcRxCtrl #(.IDX_W(IDX_W)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .rxEnable  (rxEnable),
    .huntCmd   (huntCmd),
    .irqEnable (irqEnable),
    .lastIdx   (lastIdx),
    .evt       (evt),
    .ctl       (ctl),
    .bufClose  (bufClose),
    .crcReset  (crcReset),
    .rxIrq     (rxIrq),
    .bufIdx    (bufIdx)
  );
endmodule

// File: tb/hdlcRxHunt_tb.sv
module hdlcRxHunt_tb;
  localparam int IDX_W = 4;
  localparam logic [IDX_W-1:0] LAST = 4'd3;
  localparam int NVEC = 8;
  // stimulus octets; each must come back unchanged
  localparam logic [7:0] VEC [NVEC] = '{8'h3C, 8'hFF, 8'h7E, 8'h00, 8'hF8, 8'h1F, 8'hA5, 8'hBE};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rxEnable = 1'b0, huntCmd = 1'b0, irqEnable = 1'b0;
  logic [IDX_W-1:0] lastIdx = LAST;
  logic rxBit = 1'b1, rxBitValid = 1'b0;
  logic dataValid, bufClose, crcReset, rxIrq;
  logic [7:0] dataOctet;
  logic [IDX_W-1:0] bufIdx;

  int checks = 0, errors = 0;
  int rxCnt = 0, closeCnt = 0, crcCnt = 0, irqCnt = 0;
  int lastCloseIdx = -1;
  logic [7:0] rxLog [64];
  int benchOnes = 0;
  int baseClose, baseCrc, baseIrq;
  logic [IDX_W-1:0] expIdx = '0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  hdlcRxHunt #(.IDX_W(IDX_W)) u_dut (
    .clk(clk), .rstN(rstN), .rxEnable(rxEnable), .huntCmd(huntCmd),
    .irqEnable(irqEnable), .lastIdx(lastIdx), .rxBit(rxBit),
    .rxBitValid(rxBitValid), .dataValid(dataValid), .dataOctet(dataOctet),
    .bufClose(bufClose), .bufIdx(bufIdx), .crcReset(crcReset), .rxIrq(rxIrq)
  );

  always @(negedge clk) begin
    if (rstN) begin
      if (dataValid) begin
        if (rxCnt < 64) rxLog[rxCnt] = dataOctet;
        rxCnt++;
      end
      if (bufClose) begin
        closeCnt++;
        lastCloseIdx = int'(bufIdx);
      end
      if (crcReset) crcCnt++;
      if (rxIrq) irqCnt++;
    end
  end

  task automatic check(input logic ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic sendRaw(input logic b, input logic h = 1'b0);
    @(posedge clk); #1;
    rxBit = b; rxBitValid = 1'b1; huntCmd = h;
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(posedge clk); #1;
      rxBitValid = 1'b0; rxBit = 1'b1; huntCmd = 1'b0;
    end
  endtask

  task automatic sendFlag();
    for (int i = 0; i < 8; i++) sendRaw((i != 0) && (i != 7));
    benchOnes = 0;
  endtask

  task automatic sendOctet(input logic [7:0] v, input int gap = 0);
    for (int i = 0; i < 8; i++) begin
      sendRaw(v[i]);
      if (gap > 0) idle(gap);
      if (v[i]) begin
        benchOnes++;
        if (benchOnes == 5) begin
          sendRaw(1'b0);
          benchOnes = 0;
        end
      end else begin
        benchOnes = 0;
      end
    end
  endtask

  task automatic sendRawOctet(input logic [7:0] v);
    for (int i = 0; i < 8; i++) sendRaw(v[i]);
  endtask

  task automatic pulseHunt();
    @(posedge clk); #1;
    rxBitValid = 1'b0; huntCmd = 1'b1;
    @(posedge clk); #1;
    huntCmd = 1'b0;
  endtask

  task automatic bumpIdx();
    expIdx = (expIdx == LAST) ? '0 : expIdx + 1'b1;
  endtask

  task automatic snap();
    rxCnt = 0; baseClose = closeCnt; baseCrc = crcCnt; baseIrq = irqCnt;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rstN = 1'b1;
    idle(1);
    // R1: reset state
    check(bufIdx == 0, "R1 bufIdx", bufIdx, 0);
    check({dataValid, bufClose, crcReset, rxIrq} == 4'b0, "R1 outputs",
          {dataValid, bufClose, crcReset, rxIrq}, 0);
    // R1: stream ignored before first enable
    snap();
    sendFlag(); sendOctet(8'h42); sendFlag(); idle(3);
    check(rxCnt == 0 && closeCnt == baseClose, "R1 ignored while idle", rxCnt, 0);

    // R2 R3 R4 R5 R8: vector table frame
    rxEnable = 1'b1; irqEnable = 1'b1;
    idle(2); snap();
    sendFlag();
    for (int k = 0; k < NVEC; k++) sendOctet(VEC[k]);
    sendFlag(); idle(3);
    check(rxCnt == NVEC, "R3 octet count", rxCnt, NVEC);
    for (int k = 0; k < NVEC; k++)
      check(rxLog[k] == VEC[k], "R4 octet value", rxLog[k], VEC[k]);
    check(crcCnt - baseCrc == 2, "R2 crcReset per flag", crcCnt - baseCrc, 2);
    check(closeCnt - baseClose == 1, "R5 one close", closeCnt - baseClose, 1);
    check(lastCloseIdx == 0, "R5 closed index", lastCloseIdx, 0);
    bumpIdx();
    check(bufIdx == expIdx, "R5 index advanced", bufIdx, expIdx);
    check(irqCnt - baseIrq == 1, "R8 irq enabled", irqCnt - baseIrq, 1);

    // R5: empty flags close nothing
    snap();
    sendFlag(); sendFlag(); sendFlag(); idle(3);
    check(closeCnt == baseClose, "R5 empty flags", closeCnt - baseClose, 0);

    // R12: gaps with rxBit high and valid low
    snap();
    for (int k = 0; k < 3; k++) sendOctet(VEC[k], 2);
    sendFlag(); idle(3);
    check(rxCnt == 3 && rxLog[0] == VEC[0] && rxLog[1] == VEC[1] && rxLog[2] == VEC[2],
          "R12 gaps inert", rxCnt, 3);
    bumpIdx();
    check(bufIdx == expIdx, "R12 index", bufIdx, expIdx);

    // R6: abort
    snap();
    sendOctet(8'hA5);
    for (int i = 0; i < 8; i++) sendRaw(1'b1);
    sendRawOctet(8'h33); idle(3);
    check(rxCnt == 1 && rxLog[0] == 8'hA5, "R6 abort drops rest", rxCnt, 1);
    check(closeCnt == baseClose, "R6 no close", closeCnt - baseClose, 0);
    snap();
    sendFlag(); sendOctet(8'h5A); sendFlag(); idle(3);
    check(rxCnt == 1 && rxLog[0] == 8'h5A, "R6 recovery", rxLog[0], 8'h5A);
    bumpIdx();

    // R7: hunt mid-frame
    snap();
    sendFlag(); sendOctet(8'h11); pulseHunt();
    sendRawOctet(8'h22); idle(3);
    check(rxCnt == 1 && rxLog[0] == 8'h11, "R7 frame dropped", rxCnt, 1);
    check(closeCnt - baseClose == 1, "R7 close", closeCnt - baseClose, 1);
    check(crcCnt - baseCrc == 2, "R7 crc", crcCnt - baseCrc, 2);
    check(irqCnt - baseIrq == 1, "R7 irq", irqCnt - baseIrq, 1);
    // R9: wrap from lastIdx
    check(lastCloseIdx == int'(LAST), "R9 closed last", lastCloseIdx, LAST);
    bumpIdx();
    check(bufIdx == 0 && expIdx == 0, "R9 wrap", bufIdx, 0);

    // R8: irq masked
    irqEnable = 1'b0; snap();
    pulseHunt(); idle(3);
    check(closeCnt - baseClose == 1 && irqCnt == baseIrq, "R8 irq masked", irqCnt - baseIrq, 0);
    bumpIdx();

    // R10: disable, refused re-enable, hunt, resume
    snap();
    sendFlag(); sendOctet(8'h44); idle(1);
    rxEnable = 1'b0; idle(3);
    check(closeCnt == baseClose, "R10 disable no close", closeCnt - baseClose, 0);
    rxEnable = 1'b1; idle(2); rxCnt = 0;
    sendFlag(); sendOctet(8'h55); sendFlag(); idle(3);
    check(rxCnt == 0 && closeCnt == baseClose, "R10 re-enable refused", rxCnt, 0);
    rxEnable = 1'b0; pulseHunt(); idle(2);
    check(lastCloseIdx == int'(expIdx), "R10 hunt closes", lastCloseIdx, expIdx);
    bumpIdx();
    rxEnable = 1'b1; idle(2); rxCnt = 0;
    sendFlag(); sendOctet(8'h66); sendFlag(); idle(3);
    check(rxCnt == 1 && rxLog[0] == 8'h66, "R10 resumes", rxLog[0], 8'h66);
    check(lastCloseIdx == int'(expIdx), "R10 next buffer", lastCloseIdx, expIdx);
    bumpIdx();

    // R11: hunt on last bit of closing flag
    snap();
    sendFlag(); sendOctet(8'h77);
    for (int i = 0; i < 7; i++) sendRaw(i != 0);
    sendRaw(1'b0, 1'b1);
    idle(3);
    sendRawOctet(8'h99); idle(3);
    check(closeCnt - baseClose == 1, "R11 single close", closeCnt - baseClose, 1);
    bumpIdx();
    check(bufIdx == expIdx, "R11 single advance", bufIdx, expIdx);
    check(rxCnt == 1 && rxLog[0] == 8'h77, "R11 left hunting", rxCnt, 1);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule